// File: doc/BRIEF.md
# Interleaved CPU/Video Memory Sequencer

This block lets a processor and a video fetch engine share one RAM without any request or grant handshake. From a fast master clock it derives two bus clocks of equal period, `bus_e` and `bus_q`, with `bus_q` a quarter period ahead of `bus_e`. Every bus cycle walks through four quarter phases. While `bus_e` is low the RAM belongs to the video side. While `bus_e` is high it belongs to the processor.

During the first video quarter, the RAM address comes from an internal video offset counter. At the end of the second video quarter, the byte read from RAM goes into a video holding register, a one-tick valid strobe is raised, and the offset steps forward by one. When `bus_e` rises, the RAM address switches to the processor address. Processor writes are issued only in the final quarter. Processor read data is latched as `bus_e` falls.

A new video base address can be requested at any time. It is applied only at the boundary into the next video address quarter, so a scan line is never disturbed partway through a bus cycle.

Top module: `vidmem_sequencer`

## Requirements
- R1: Each quarter phase lasts TICKS_PER_PHASE master ticks. The pair (`bus_e`,`bus_q`) steps through the encodings (0,0) -> (0,1) -> (1,1) -> (1,0) and back to (0,0). Both are registered outputs and both are low after reset.
- R2: While `bus_e` is low, `ram_addr` equals the current video offset.
- R3: While `bus_e` is high, `ram_addr` equals `cpu_addr`.
- R4: `ram_we` is high exactly when (`bus_e`,`bus_q`) = (1,0) and `cpu_rnw` is 0. `ram_wdata` always equals `cpu_wdata`.
- R5: On the last master tick of the (0,1) quarter, `ram_rdata` is captured into `vid_data`. `vid_valid` is high for exactly the one following tick, so it pulses once per bus cycle.
- R6: The video offset rises by one, modulo 2^ADDR_W, after each video capture.
- R7: On the last master tick of the (1,0) quarter, `ram_rdata` is captured into `cpu_rdata`. At all other times `cpu_rdata` holds its value.
- R8: When `vid_base_load` is sampled high, `vid_base` becomes the offset at the start of the next (0,0) quarter and not before. If several loads arrive before that boundary, the last one wins. A load on the boundary tick itself is applied at that boundary.
- R9: After reset the phase is (0,0) at its first tick, the video offset is 0, `ram_we` and `vid_valid` are 0, and `vid_data` and `cpu_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_rnw | input | 1 | Processor read (1) or write (0) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, latched as bus_e falls |
| vid_base_load | input | 1 | Request to load a new video base |
| vid_base | input | ADDR_W | New video base address |
| ram_addr | output | ADDR_W | Shared RAM address |
| ram_wdata | output | DATA_W | Shared RAM write data |
| ram_rdata | input | DATA_W | Shared RAM read data (asynchronous read) |
| ram_we | output | 1 | Shared RAM write enable |
| vid_data | output | DATA_W | Last video byte fetched |
| vid_valid | output | 1 | One-tick strobe marking a new video byte |
| bus_e | output | 1 | Derived bus clock E |
| bus_q | output | 1 | Derived quadrature bus clock Q, leading E |

## Verification
The bound checker watches the local rules on every tick:
- the legal E/Q edge ordering,
- write enable confined to the processor data quarter,
- the processor address on the RAM bus while E is high,
- the single-tick shape of the video strobe and its position,
- processor read data changing only where E falls.

Other behaviour depends on the bench's reference model and its memory contents:
- the exact quarter lengths,
- the video offset sequence with its wraparound,
- the deferred and overriding base loads,
- the byte values that reach each consumer.

// File: rtl/sq_pkg.sv
package sq_pkg;

   // Quarter-phase encoding: bit 1 is E, bit1^bit0 is Q.
   typedef enum logic [1:0] {
      PH_VID_ADDR = 2'd0,
      PH_VID_READ = 2'd1,
      PH_CPU_ADDR = 2'd2,
      PH_CPU_DATA = 2'd3
   } sq_phase_e;

endpackage

// File: rtl/sq_phase_gen.sv
module sq_phase_gen
   import sq_pkg::*;
#(
   parameter int TICKS_PER_PHASE = 4
) (
   input  logic      clk,
   input  logic      rst,
   output sq_phase_e phase,
   output logic      last_tick,
   output logic      bus_e,
   output logic      bus_q
);

   localparam int TICK_W = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1;

   generate
      if (TICKS_PER_PHASE < 1) begin : g_bad_ticks
         $error("TICKS_PER_PHASE must be at least 1");
      end

      if (TICKS_PER_PHASE == 1) begin : g_single
         assign last_tick = 1'b1;
      end else begin : g_divided
         logic [TICK_W-1:0] tick;
         always_ff @(posedge clk) begin
            if (rst)
               tick <= '0;
            else if (tick == TICK_W'(TICKS_PER_PHASE - 1))
               tick <= '0;
            else
               tick <= tick + 1'b1;
         end
         assign last_tick = (tick == TICK_W'(TICKS_PER_PHASE - 1));
      end
   endgenerate

   sq_phase_e phase_nxt;

   always_comb begin
      if (last_tick)
         phase_nxt = sq_phase_e'(2'(phase + 2'd1));
      else
         phase_nxt = phase;
   end

   // E and Q are taken from flops so that decode glitches never reach them.
   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_VID_ADDR;
         bus_e <= 1'b0;
         bus_q <= 1'b0;
      end else begin
         phase <= phase_nxt;
         bus_e <= phase_nxt[1];
         bus_q <= phase_nxt[1] ^ phase_nxt[0];
      end
   end

endmodule

// File: rtl/sq_vid_ctr.sv
module sq_vid_ctr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              apply,
   input  logic              step,
   output logic [ADDR_W-1:0] vofs
);

   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;

   always_ff @(posedge clk) begin
      if (rst) begin
         vofs      <= '0;
         pend_v    <= 1'b0;
         pend_addr <= '0;
      end else if (apply) begin
         // A load arriving on the boundary tick is applied at once.
         if (load)
            vofs <= base;
         else if (pend_v)
            vofs <= pend_addr;
         pend_v <= 1'b0;
      end else begin
         if (step)
            vofs <= vofs + 1'b1;
         if (load) begin
            pend_v    <= 1'b1;
            pend_addr <= base;
         end
      end
   end

endmodule

// File: rtl/sq_capture.sv
module sq_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic              vid_take,
   input  logic              cpu_take,
   output logic [DATA_W-1:0] vid_data,
   output logic              vid_valid,
   output logic [DATA_W-1:0] cpu_rdata
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vid_data  <= '0;
         vid_valid <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         vid_valid <= vid_take;
         if (vid_take)
            vid_data <= ram_rdata;
         if (cpu_take)
            cpu_rdata <= ram_rdata;
      end
   end

endmodule

// File: rtl/vidmem_sequencer.sv
module vidmem_sequencer
   import sq_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int TICKS_PER_PHASE = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rnw,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              vid_base_load,
   input  logic [ADDR_W-1:0] vid_base,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_we,
   output logic [DATA_W-1:0] vid_data,
   output logic              vid_valid,
   output logic              bus_e,
   output logic              bus_q
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   sq_phase_e         phase;
   logic              last_tick;
   logic [ADDR_W-1:0] vofs;
   logic              vid_take;
   logic              cpu_take;

   sq_phase_gen #(
      .TICKS_PER_PHASE(TICKS_PER_PHASE)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .phase    (phase),
      .last_tick(last_tick),
      .bus_e    (bus_e),
      .bus_q    (bus_q)
   );

   assign vid_take = last_tick && (phase == PH_VID_READ);
   assign cpu_take = last_tick && (phase == PH_CPU_DATA);

   sq_vid_ctr #(
      .ADDR_W(ADDR_W)
   ) u_vctr (
      .clk  (clk),
      .rst  (rst),
      .load (vid_base_load),
      .base (vid_base),
      .apply(cpu_take),
      .step (vid_take),
      .vofs (vofs)
   );

   sq_capture #(
      .DATA_W(DATA_W)
   ) u_cap (
      .clk      (clk),
      .rst      (rst),
      .ram_rdata(ram_rdata),
      .vid_take (vid_take),
      .cpu_take (cpu_take),
      .vid_data (vid_data),
      .vid_valid(vid_valid),
      .cpu_rdata(cpu_rdata)
   );

   always_comb begin
      ram_addr = phase[1] ? cpu_addr : vofs;
   end

   assign ram_we    = (phase == PH_CPU_DATA) && !cpu_rnw;
   assign ram_wdata = cpu_wdata;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rnw,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              ram_we,
   input logic              vid_valid,
   input logic              bus_e,
   input logic              bus_q
);

   // R1: Q is already high when E rises
   p_e_rise_order_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_e) |-> bus_q);
   // R1: E is still low when Q rises
   p_q_rise_order_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_q) |-> !bus_e);
   // R1: Q is already low when E falls
   p_e_fall_order_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_e) |-> !bus_q);
   // R1: E is still high when Q falls
   p_q_fall_order_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_q) |-> bus_e);
   // R3: the processor owns the RAM address while E is high
   p_cpu_addr_r3: assert property (@(posedge clk) disable iff (rst)
      bus_e |-> (ram_addr == cpu_addr));
   // R4: writes only in the processor data quarter, only for a write request
   p_we_slot_r4: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> (bus_e && !bus_q && !cpu_rnw));
   // R5: the video strobe lasts one tick
   p_vvalid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      vid_valid |=> !vid_valid);
   // R5: the strobe follows the video read quarter
   p_vvalid_pos_r5: assert property (@(posedge clk) disable iff (rst)
      vid_valid |-> (bus_e && bus_q));
   // R7: processor read data changes only where E falls
   p_cpu_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !$stable(cpu_rdata) |-> $fell(bus_e));

endmodule

bind vidmem_sequencer sq_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_sq_checker (
   .clk      (clk),
   .rst      (rst),
   .cpu_addr (cpu_addr),
   .cpu_rnw  (cpu_rnw),
   .cpu_rdata(cpu_rdata),
   .ram_addr (ram_addr),
   .ram_we   (ram_we),
   .vid_valid(vid_valid),
   .bus_e    (bus_e),
   .bus_q    (bus_q)
);

// File: tb/vidmem_sequencer_bench.sv
module vidmem_sequencer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;
   localparam int DATA_W     = 8;
   localparam int TICKS      = 4;
   localparam int DEPTH      = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic              cpu_rnw = 1'b1;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              vid_base_load = 1'b0;
   logic [ADDR_W-1:0] vid_base = '0;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata;
   logic [DATA_W-1:0] ram_rdata;
   logic              ram_we;
   logic [DATA_W-1:0] vid_data;
   logic              vid_valid;
   logic              bus_e;
   logic              bus_q;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vidmem_sequencer #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .TICKS_PER_PHASE(TICKS)
   ) u_vidmem_sequencer (
      .clk(clk), .rst(rst),
      .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata),
      .vid_base_load(vid_base_load), .vid_base(vid_base),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .ram_we(ram_we), .vid_data(vid_data), .vid_valid(vid_valid),
      .bus_e(bus_e), .bus_q(bus_q)
   );

   // RAM model: asynchronous read, write on the clock
   logic [DATA_W-1:0] mem [DEPTH];
   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i * 7 + 3);
   end
   assign ram_rdata = mem[ram_addr];
   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

   // Reference model built from the requirements
   int                m_tick;
   logic [1:0]        m_phase;
   logic [ADDR_W-1:0] m_vofs;
   bit                m_pend;
   logic [ADDR_W-1:0] m_pend_addr;
   logic [DATA_W-1:0] m_vdata;
   bit                m_vvalid;
   logic [DATA_W-1:0] m_crd;

   function automatic logic exp_e(input logic [1:0] ph);
      return ph[1];
   endfunction
   function automatic logic exp_q(input logic [1:0] ph);
      return (ph == 2'd1) || (ph == 2'd2);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_tick <= 0; m_phase <= 2'd0; m_vofs <= '0; m_pend <= 1'b0;
         m_pend_addr <= '0; m_vdata <= '0; m_vvalid <= 1'b0; m_crd <= '0;
      end else begin
         bit last;
         last = (m_tick == TICKS - 1);
         m_tick   <= last ? 0 : m_tick + 1;
         m_phase  <= last ? m_phase + 2'd1 : m_phase;
         m_vvalid <= 1'b0;
         if (last && m_phase == 2'd1) begin
            m_vdata  <= mem[m_vofs];
            m_vvalid <= 1'b1;
            m_vofs   <= m_vofs + 1'b1;
         end
         if (last && m_phase == 2'd3) begin
            m_crd <= mem[cpu_addr];
            if (vid_base_load) m_vofs <= vid_base;
            else if (m_pend)   m_vofs <= m_pend_addr;
            m_pend <= 1'b0;
         end else if (vid_base_load) begin
            m_pend <= 1'b1;
            m_pend_addr <= vid_base;
         end
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t",
                  req, what, act, exp, $time);
      end
   endtask

   // Compare every tick, half a period after the model updates
   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R1", "bus_e", 32'(bus_e), 32'(exp_e(m_phase)));
         check("R1", "bus_q", 32'(bus_q), 32'(exp_q(m_phase)));
         if (m_phase[1])
            check("R3", "ram_addr cpu", 32'(ram_addr), 32'(cpu_addr));
         else
            check("R2", "ram_addr video", 32'(ram_addr), 32'(m_vofs));
         check("R4", "ram_we", 32'(ram_we), 32'((m_phase == 2'd3) && !cpu_rnw));
         check("R4", "ram_wdata", 32'(ram_wdata), 32'(cpu_wdata));
         check("R5", "vid_valid", 32'(vid_valid), 32'(m_vvalid));
         check("R5", "vid_data", 32'(vid_data), 32'(m_vdata));
         check("R7", "cpu_rdata", 32'(cpu_rdata), 32'(m_crd));
      end
   end

   task automatic wait_phase(input logic [1:0] ph, input int tick);
      do @(negedge clk); while (!(m_phase == ph && m_tick == tick));
      #1;
   endtask

   task automatic load_base(input logic [ADDR_W-1:0] b);
      vid_base_load = 1'b1; vid_base = b;
      @(negedge clk); #1;
      vid_base_load = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R9: reset state, observed while reset is held
      check("R9", "bus_e reset", 32'(bus_e), 0);
      check("R9", "bus_q reset", 32'(bus_q), 0);
      check("R9", "ram_we reset", 32'(ram_we), 0);
      check("R9", "vid_valid reset", 32'(vid_valid), 0);
      check("R9", "vid_data reset", 32'(vid_data), 0);
      check("R9", "cpu_rdata reset", 32'(cpu_rdata), 0);
      check("R9", "ram_addr offset reset", 32'(ram_addr), 0);
      #1 rst = 1'b0;

      // R6: offsets 0,1,2 fetched in order
      repeat (3) begin
         wait_phase(2'd2, 0);
         check("R6", "offset step via vid_data", 32'(vid_data), 32'(m_vdata));
      end

      // R8: load mid-cycle is deferred to the next video address quarter
      wait_phase(2'd1, 1);
      load_base(10'h155);
      check("R8", "deferred load not yet visible", 32'(ram_addr), 32'(m_vofs));
      wait_phase(2'd0, 0);
      check("R8", "deferred load applied", 32'(ram_addr), 32'h155);

      // R8: two loads before the boundary, the later one wins
      wait_phase(2'd2, 1);
      load_base(10'h020);
      load_base(10'h3FF);
      wait_phase(2'd0, 0);
      check("R8", "last load wins", 32'(ram_addr), 32'h3FF);

      // R6: wrap from the top of the address space
      wait_phase(2'd2, 0);
      wait_phase(2'd0, 0);
      check("R6", "offset wraps to zero", 32'(ram_addr), 0);

      // R8: load on the boundary tick itself
      wait_phase(2'd3, TICKS - 1);
      load_base(10'h0AB);
      check("R8", "boundary load applied", 32'(ram_addr), 32'h0AB);

      // R4/R7: directed write then read back at one address
      wait_phase(2'd0, 0);
      cpu_addr = 10'h012; cpu_rnw = 1'b0; cpu_wdata = 8'hC5;
      wait_phase(2'd0, 0);
      cpu_rnw = 1'b1;
      wait_phase(2'd0, 0);
      check("R7", "read back written byte", 32'(cpu_rdata), 32'hC5);

      // Constrained random: processor signals change only at a bus cycle start
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk); #1;
         if (m_phase == 2'd0 && m_tick == 0) begin
            cpu_addr  = ADDR_W'($urandom);
            cpu_rnw   = ($urandom % 4) != 0;
            cpu_wdata = DATA_W'($urandom);
         end
         vid_base_load = ($urandom % 40) == 0;
         vid_base      = ADDR_W'($urandom);
      end
      vid_base_load = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule